// File: doc/BRIEF.md
# Handshaked FIFO Memory DMA Engine

This engine moves bytes between an internal byte FIFO and an external memory through a four-phase request/acknowledge handshake. The memory acknowledge is active low and asynchronous to the engine clock. On the device side, bytes travel on a simple valid/ready byte stream. Software starts a transfer with a pulse on `start`. That pulse loads a byte count, a base address and a direction. The engine then runs until the count is used up or a phase error cuts the transfer short.

In the outbound direction (memory to device) the engine prefetches into the FIFO while there is room. Once eight or fewer bytes remain, it fetches only into an empty FIFO, one byte at a time. In the inbound direction it writes to memory whenever the FIFO holds a byte. An inbound phase error holds off the device-side acknowledge until the FIFO has been flushed to memory, and then raises an interrupt pulse. An outbound phase error stops fetching and leaves the FIFO residue visible, so that software can rewind its address pointer by that amount.

Top module: `fifo_mem_dma`

## Requirements
- R1: A memory cycle raises `mem_req` only while the synchronized `mem_ack_n` is high. `mem_req` stays high until the synchronized `mem_ack_n` reads low and then drops. The next cycle does not start before `mem_ack_n` has returned high.
- R2: Outbound (`dir_out`=1): memory read cycles are issued while the FIFO holds fewer than DEPTH bytes and stop while it is full. They resume when the device drains it. Addresses run `xfer_base`, `xfer_base`+1, and so on. Bytes appear on `dout_data` in that address order.
- R3: Inbound (`dir_out`=0): a memory write cycle (`mem_we`=1) starts whenever the FIFO holds a byte. Bytes taken on `din_data` are written in arrival order to consecutive addresses from `xfer_base`.
- R4: `count` shows the bytes still to move on the device side and drops by one per device transfer. When it reaches zero and no memory cycle is open (and, inbound, the FIFO is empty), `done` pulses for one cycle and `busy` falls. A start with length 0 gives `done` with no memory cycle.
- R5: Between the fall of `mem_req` and its next rise there are at least GAP_CLKS clock cycles.
- R6: Outbound, once `count` is at or below TAIL (8), a new memory cycle starts only when `residue` is 0.
- R7: After an inbound `phase_err`, `din_ready` is low and `dev_ack_hold` is high while the FIFO drains to memory. When the FIFO is empty, `dev_ack_hold` falls, `irq` pulses and `done` stays low. Every byte accepted before the error is written, and `count` keeps the untransferred bytes.
- R8: After an outbound `phase_err`, no new memory cycle starts and `dout_valid` is low. `irq` pulses once the open cycle closes. `residue` holds the bytes fetched but not delivered until the next start, and `count` holds the bytes not delivered.
- R9: A `start` pulse while `busy` is high has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a transfer when idle |
| dir_out | input | 1 | 1 = memory to device, 0 = device to memory |
| xfer_len | input | CNT_W | Byte count loaded at start |
| xfer_base | input | ADDR_W | First memory address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| irq | output | 1 | One-cycle pulse when an error stop completes |
| count | output | CNT_W | Bytes left on the device side |
| residue | output | CW | Bytes held in the FIFO |
| mem_req | output | 1 | Memory cycle request |
| mem_ack_n | input | 1 | Asynchronous active-low memory acknowledge |
| mem_we | output | 1 | 1 for a memory write cycle |
| mem_addr | output | ADDR_W | Memory address of the current cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while acknowledge is low |
| din_valid | input | 1 | Device byte offered |
| din_ready | output | 1 | Engine accepts device byte |
| din_data | input | 8 | Device byte in |
| dout_valid | output | 1 | Byte offered to device |
| dout_ready | input | 1 | Device accepts byte |
| dout_data | output | 8 | Byte to device |
| phase_err | input | 1 | Phase mismatch or disconnect |
| dev_ack_hold | output | 1 | Device acknowledge withheld during flush |

## Verification
The bench watches every rise of the request against the values `count` and `residue` held one cycle before. A design that keeps prefetching near the end of a transfer starts a memory read while bytes still wait in the FIFO. A design that ignores a full FIFO issues a seventeenth read while the device stalls. The error paths are driven with a slow memory so that bytes are still queued when the error arrives. A design that releases the acknowledge early, or drops queued bytes, then shows `dev_ack_hold` low or a missing memory word. The outbound abort checks that the residue stays frozen and that no fetch follows. Zero-length starts and starts issued mid-transfer catch a design that opens a memory cycle for nothing, or one that reloads its pointer.

// File: rtl/fifo_mem_dma.sv
module fifo_mem_dma #(
  parameter int CNT_W    = 24,
  parameter int ADDR_W   = 24,
  parameter int DEPTH    = 16,
  parameter int GAP_CLKS = 4,
  parameter int TAIL     = 8,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_out,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic [ADDR_W-1:0] xfer_base,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic [CNT_W-1:0]  count,
  output logic [CW-1:0]     residue,
  output logic              mem_req,
  input  logic              mem_ack_n,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [7:0]        dout_data,
  input  logic              phase_err,
  output logic              dev_ack_hold
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int GW = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {HS_IDLE, HS_REQ, HS_REL, HS_GAP} hs_e;

  hs_e               hs;
  logic [GW-1:0]     gcnt;
  logic              ack_m, ack_s;
  logic              dir_q, flush_q, abort_q;
  logic [CNT_W-1:0]  fetch_q;
  logic [7:0]        fifo_q [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     fcnt;

  wire full     = (fcnt == CW'(DEPTH));
  wire empty    = (fcnt == '0);
  wire quiet    = (hs == HS_IDLE) || (hs == HS_GAP);
  wire mem_done = (hs == HS_REQ) && !ack_s;
  wire dev_in   = din_valid && din_ready;
  wire dev_out  = dout_valid && dout_ready;
  wire push     = dir_q ? mem_done : dev_in;
  wire pop      = dir_q ? dev_out : mem_done;
  wire tail_ok  = (count > CNT_W'(TAIL)) || empty;
  wire go       = busy && (hs == HS_IDLE) &&
                  (dir_q ? (!abort_q && fetch_q != '0 && !full && tail_ok) : !empty);
  wire fin_ok   = busy && quiet && count == '0 &&
                  (dir_q ? !abort_q : (empty && !flush_q));
  wire err_end  = busy && quiet && (dir_q ? abort_q : (flush_q && empty));

  assign residue      = fcnt;
  assign mem_req      = (hs == HS_REQ);
  assign mem_we       = !dir_q;
  assign mem_wdata    = fifo_q[rp];
  assign dout_data    = fifo_q[rp];
  assign dout_valid   = busy && dir_q && !abort_q && !empty;
  assign din_ready    = busy && !dir_q && !flush_q && count != '0 && !full;
  assign dev_ack_hold = flush_q;

  always_ff @(posedge clk) begin
    if (!rst_n) {ack_s, ack_m} <= 2'b11;
    else        {ack_s, ack_m} <= {ack_m, mem_ack_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs   <= HS_IDLE;
      gcnt <= '0;
    end else begin
      unique case (hs)
        HS_IDLE: if (go) hs <= HS_REQ;
        HS_REQ:  if (!ack_s) hs <= HS_REL;
        HS_REL:  if (ack_s) begin hs <= HS_GAP; gcnt <= '0; end
        HS_GAP:  if (gcnt == GW'(GAP_CLKS - 1)) hs <= HS_IDLE;
                 else gcnt <= gcnt + GW'(1);
        default: hs <= HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_q <= 1'b0; flush_q <= 1'b0; abort_q <= 1'b0;
      count <= '0; fetch_q <= '0; mem_addr <= '0; done <= 1'b0; irq <= 1'b0;
    end else begin
      done <= 1'b0;
      irq  <= 1'b0;
      if (!busy && start) mem_addr <= xfer_base;
      else if (hs == HS_REL && ack_s) mem_addr <= mem_addr + ADDR_W'(1);
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; dir_q <= dir_out; count <= xfer_len; fetch_q <= xfer_len;
          flush_q <= 1'b0; abort_q <= 1'b0;
        end
      end else if (fin_ok) begin
        busy <= 1'b0; done <= 1'b1;
      end else if (err_end) begin
        busy <= 1'b0; irq <= 1'b1; flush_q <= 1'b0; abort_q <= 1'b0;
      end else begin
        if (phase_err) begin
          if (dir_q) abort_q <= 1'b1;
          else       flush_q <= 1'b1;
        end
        if (dev_in || dev_out) count <= count - CNT_W'(1);
        if (dir_q && mem_done) fetch_q <= fetch_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (!busy && start)) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      fcnt <= fcnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo_q[wp] <= dir_q ? mem_rdata : din_data;
  end
endmodule

// File: rtl/fifo_mem_dma_chk.sv
module fifo_mem_dma_chk #(
  parameter int CNT_W    = 24,
  parameter int DEPTH    = 16,
  parameter int GAP_CLKS = 4,
  parameter int TAIL     = 8,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             ack_s,
  input logic             dir_q,
  input logic             busy,
  input logic             done,
  input logic             din_ready,
  input logic             dev_ack_hold,
  input logic [CNT_W-1:0] count,
  input logic [CW-1:0]    residue
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          low_cnt <= 8'hFF;
    else if (mem_req)    low_cnt <= '0;
    else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
  end

  AST_REQ_RISE_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(ack_s)); // R1
  AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> !$past(ack_s)); // R1
  AST_NO_FETCH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && dir_q) |-> ($past(residue) != CW'(DEPTH))); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req)); // R4
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (int'(low_cnt) >= GAP_CLKS)); // R5
  AST_TAIL_WAITS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && dir_q && $past(count) <= CNT_W'(TAIL)) |-> ($past(residue) == '0)); // R6
  AST_HOLD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack_hold |-> !din_ready); // R7
endmodule

bind fifo_mem_dma fifo_mem_dma_chk #(
  .CNT_W(CNT_W), .DEPTH(DEPTH), .GAP_CLKS(GAP_CLKS), .TAIL(TAIL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .ack_s(ack_s), .dir_q(dir_q),
  .busy(busy), .done(done), .din_ready(din_ready), .dev_ack_hold(dev_ack_hold),
  .count(count), .residue(residue)
);

// File: tb/fifo_mem_dma_tb.sv
module fifo_mem_dma_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int GAP   = 4;
  localparam int TAIL  = 8;

  logic clk = 0, rst_n = 0, start = 0, dir_out = 0;
  logic [23:0] xfer_len = 0, xfer_base = 0;
  logic busy, done, irq, mem_req, mem_we, din_ready, dout_valid, dev_ack_hold;
  logic [23:0] count, mem_addr;
  logic [4:0] residue;
  logic mem_ack_n, din_valid, dout_ready, phase_err = 0;
  logic [7:0] mem_wdata, mem_rdata, din_data, dout_data;

  fifo_mem_dma u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_out(dir_out), .xfer_len(xfer_len),
    .xfer_base(xfer_base), .busy(busy), .done(done), .irq(irq), .count(count),
    .residue(residue), .mem_req(mem_req), .mem_ack_n(mem_ack_n), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .phase_err(phase_err), .dev_ack_hold(dev_ack_hold));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int cur_dir = 1, cur_len = 0, cur_base = 0;
  int out_idx = 0, in_idx = 0, mem_cyc = 0;
  int mem_dly = 0, rdy_mode = 1;
  bit src_en = 0;
  bit done_seen, irq_seen;
  logic [7:0] wmem [1024];

  function automatic logic [7:0] mdata(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] sdata(input int i);
    return 8'(i * 7 + 8'h3C);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic nstep();
    @(negedge clk); #2;
  endtask

  // memory responder
  initial begin
    mem_ack_n = 1; mem_rdata = 0;
    forever begin
      nstep();
      if (mem_req && mem_ack_n) begin
        chk(mem_addr == 24'(cur_base + mem_cyc), "R2/R3 address order", mem_addr, 24'(cur_base + mem_cyc));
        chk(mem_we == (cur_dir == 0), "R3 cycle direction", mem_we, cur_dir == 0);
        repeat ($urandom % (mem_dly + 1)) nstep();
        if (cur_dir == 1) mem_rdata = mdata(int'(mem_addr));
        else wmem[mem_addr[9:0]] = mem_wdata;
        mem_cyc++;
        mem_ack_n = 0;
        while (mem_req) nstep();
        repeat ($urandom % (mem_dly + 1)) nstep();
        mem_ack_n = 1;
      end
    end
  end

  // handshake monitor
  initial begin
    logic prev_req = 0;
    int low_cnt = 100;
    int prev_count = 0, prev_res = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_req && !prev_req) begin
          chk(mem_ack_n == 1, "R1 ack high at request rise", mem_ack_n, 1);
          chk(low_cnt >= GAP, "R5 request spacing", low_cnt, GAP);
          if (cur_dir == 1) begin
            chk(prev_res < DEPTH, "R2 no fetch into full FIFO", prev_res, DEPTH - 1);
            if (prev_count <= TAIL)
              chk(prev_res == 0, "R6 tail fetch needs empty FIFO", prev_res, 0);
          end
        end
        if (!mem_req && prev_req)
          chk(mem_ack_n == 0, "R1 request held until ack low", mem_ack_n, 0);
        low_cnt = mem_req ? 0 : low_cnt + 1;
        prev_req = mem_req;
        prev_count = int'(count);
        prev_res = int'(residue);
      end
    end
  end

  // device sink
  initial begin
    dout_ready = 0;
    forever begin
      @(negedge clk);
      dout_ready = (rdy_mode == 1) || (rdy_mode == 2 && ($urandom % 2) == 1);
      #1;
      if (dout_valid && dout_ready) begin
        chk(dout_data == mdata(cur_base + out_idx), "R2 outbound data order", dout_data, mdata(cur_base + out_idx));
        out_idx++;
      end
    end
  end

  // device source
  initial begin
    din_valid = 0; din_data = 0;
    forever begin
      @(negedge clk);
      if (src_en && in_idx < cur_len) begin
        din_valid = ($urandom % 4) != 0;
        din_data = sdata(in_idx);
      end else din_valid = 0;
      #1;
      if (din_valid && din_ready) in_idx++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic kick(input int d, input int len, input int base);
    cur_dir = d; cur_len = len; cur_base = base;
    out_idx = 0; in_idx = 0; mem_cyc = 0;
    @(negedge clk);
    dir_out = d[0]; xfer_len = 24'(len); xfer_base = 24'(base); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    int t = 0;
    do begin @(negedge clk); t++; end while (!done && !irq && t < 30000);
    done_seen = done; irq_seen = irq;
  endtask

  task automatic check_inbound(input string tag);
    bit ok = 1;
    for (int i = 0; i < in_idx; i++)
      if (wmem[(cur_base + i) % 1024] != sdata(i)) ok = 0;
    chk(ok, tag, ok, 1);
  endtask

  task automatic clear_region(input int base, input int len);
    for (int i = 0; i < len; i++) wmem[(base + i) % 1024] = ~sdata(i);
  endtask

  initial begin
    void'($urandom(32'h1D5));
    repeat (3) @(negedge clk);
    chk(!mem_req && !busy && !done && !irq, "R4 reset idle outputs", {mem_req, busy, done, irq}, 0);
    chk(residue == 0 && count == 0 && !dev_ack_hold, "R4 reset counters", residue, 0);
    rst_n = 1;

    // outbound, random device stalls
    rdy_mode = 2; mem_dly = 2;
    kick(1, 40, 'h100); wait_end();
    chk(done_seen && !irq_seen, "R4 outbound done pulse", done_seen, 1);
    chk(out_idx == 40 && mem_cyc == 40, "R2 outbound byte total", out_idx, 40);
    chk(count == 0 && !busy, "R4 count zero at done", count, 0);

    // short transfer lives in the tail window
    mem_dly = 0;
    kick(1, 12, 'h180); wait_end();
    chk(done_seen && out_idx == 12, "R6 tail transfer completes", out_idx, 12);

    // zero length
    kick(1, 0, 'h10); wait_end();
    chk(done_seen && mem_cyc == 0, "R4 zero length no memory cycle", mem_cyc, 0);

    // inbound
    mem_dly = 1; clear_region('h200, 30); src_en = 1;
    kick(0, 30, 'h200); wait_end(); src_en = 0;
    chk(done_seen && in_idx == 30 && mem_cyc == 30, "R3 inbound totals", mem_cyc, 30);
    check_inbound("R3 inbound memory image");

    // start while busy
    rdy_mode = 2; mem_dly = 1;
    kick(1, 20, 'h2A0);
    repeat (5) @(negedge clk);
    dir_out = 0; xfer_len = 3; xfer_base = 'h3F0; start = 1;
    @(negedge clk); start = 0;
    wait_end();
    chk(done_seen && out_idx == 20 && mem_cyc == 20, "R9 start ignored while busy", out_idx, 20);

    // inbound phase error with slow memory
    mem_dly = 6; clear_region('h300, 10); src_en = 1;
    kick(0, 10, 'h300);
    for (int t = 0; t < 2000 && in_idx < 6; t++) @(negedge clk);
    src_en = 0; phase_err = 1;
    @(negedge clk); phase_err = 0;
    chk(dev_ack_hold && !din_ready, "R7 hold asserted on error", {dev_ack_hold, din_ready}, 2'b10);
    wait_end();
    chk(irq_seen && !done_seen, "R7 irq after flush", irq_seen, 1);
    chk(!dev_ack_hold && residue == 0, "R7 hold released with FIFO empty", residue, 0);
    chk(count == 24'(10 - in_idx), "R7 count keeps untransferred bytes", count, 10 - in_idx);
    chk(mem_cyc == in_idx, "R7 all accepted bytes flushed", mem_cyc, in_idx);
    check_inbound("R7 flushed memory image");

    // outbound phase error with stalled device
    mem_dly = 0; rdy_mode = 0;
    kick(1, 30, 'h40);
    for (int t = 0; t < 2000 && residue != 5'(DEPTH); t++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(mem_cyc == DEPTH, "R2 fetch pauses at full", mem_cyc, DEPTH);
    phase_err = 1;
    @(negedge clk); phase_err = 0;
    wait_end();
    chk(irq_seen && !done_seen, "R8 irq on outbound abort", irq_seen, 1);
    chk(residue == 5'(DEPTH) && count == 30, "R8 residue and count kept", residue, DEPTH);
    repeat (20) @(negedge clk);
    chk(!mem_req && !dout_valid && mem_cyc == DEPTH, "R8 no fetch after abort", mem_cyc, DEPTH);
    chk(residue == 5'(DEPTH), "R8 residue held until next start", residue, DEPTH);

    // random transfers
    rdy_mode = 2;
    for (int k = 0; k < 8; k++) begin
      int d = $urandom % 2;
      int len = 1 + $urandom % 40;
      int base = $urandom % 768;
      mem_dly = $urandom % 4;
      if (d == 0) begin clear_region(base, len); src_en = 1; end
      kick(d, len, base); wait_end(); src_en = 0;
      chk(done_seen && mem_cyc == len, "R4 random transfer completes", mem_cyc, len);
      if (d == 1) chk(out_idx == len, "R2 random outbound total", out_idx, len);
      else check_inbound("R3 random inbound image");
    end

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule